// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block drives a key matrix of `NUM_ROWS` row lines and reads `NUM_COLS` active-low column returns that have pull-ups. By default the matrix is 5 by 6, which gives 30 keys. While nothing is happening, every row is held low. With every row low, a pressed key pulls its column low, so the column bus shows a compressed view of the whole matrix. The block compares that view with the view implied by the last key image it stored. When the two differ, a key has been pressed or released, and the block starts scanning.

During a scan the block pulls one row low at a time and leaves the others high. Each row is held for `ROW_TICKS` pulses of the `tick` timebase. The columns are sampled on the last tick of each row and written into that row's slice of a key image. When the first complete pass over all rows ends, `int_o` rises. It stays high, and scanning keeps cycling, until the host strobes `stop_req`. If the image changes after `int_o` has risen and before the stop arrives, that stop only causes a short pause of one row period with all rows low. Scanning then restarts from row 0, and the host has to stop it a second time. A `read_req` strobe copies the live image into the `key_image` output, which a serial shifter outside this block then sends out, bit 0 first.

With a 3.3 MHz oscillator, the typical figures are a row pulse of about 78 µs and a full pass of about 390 µs. `ROW_TICKS` and the tick rate are chosen to give these figures.

Top module: `keyscan_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `row_drv` is all zeros, `int_o` is 0 and `key_image` is all zeros.
- R2: In the idle state every row is driven low. The block stays idle while the column bus matches the idle baseline. The baseline is: column c is high exactly when no key in column c is marked pressed in the stored image.
- R3: When a column reads low and the baseline says it should be high (a press), scanning starts with row 0 selected. In that state `row_drv` equals all ones with bit 0 cleared.
- R4: While scanning, exactly one bit of `row_drv` is low. Each row stays selected for `ROW_TICKS` ticks. Rows are selected in the order 0, 1, …, NUM_ROWS-1, and then row 0 again.
- R5: On the last tick of a row pulse, bit r*NUM_COLS+c of the image becomes 1 when column c reads low (pressed) and 0 when it reads high.
- R6: `int_o` rises on the clock edge that completes the first full pass after a start. It stays high until a stop is accepted.
- R7: A stop accepted while scanning, with no pending change, clears `int_o`, drives every row low and returns the block to idle.
- R8: If a row sample differs from the stored image while `int_o` is high, the next stop gives only a pause of `ROW_TICKS` ticks with all rows low. Scanning then restarts at row 0 with `int_o` low, and a later stop is needed to return to idle.
- R9: `stop_req` has no effect while the block is idle or pausing.
- R10: On each clock where `read_req` is high, `key_image` takes the image as it stood before that edge. Bit 0 holds row 0 / column 0, the key that is sent out first. At every other time `key_image` holds its value.
- R11: When a column reads high and the baseline says it should be low (a release), scanning starts in the same way as for a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Scan timebase enable, one clock wide |
| col_n | input | NUM_COLS | Active-low column returns |
| stop_req | input | 1 | Host stop command strobe |
| read_req | input | 1 | Strobe that copies the live image to `key_image` |
| row_drv | output | NUM_ROWS | Row drive levels; a low bit selects that row |
| int_o | output | 1 | Interrupt to the host |
| key_image | output | NUM_ROWS*NUM_COLS | Captured key image, 1 = pressed |

## Verification
The hardest case to reach is the second-stop path. It needs a key change that a row sample sees only after `int_o` has risen, and it needs a stop that arrives after that sample. The bench presses a new key while scanning continues with the interrupt high. It waits more than two full passes and only then strobes stop. Next it strobes stop again inside the pause window, to show that this stop is ignored. After that it checks that scanning resumes without any new key activity. A behavioural model that runs alongside the design follows the idle baseline. This shows whether the block wakes up falsely when it returns to idle with a key still held down.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_PAUSE = 2'd2
  } ks_state_t;

  localparam int SETTLE_CYCLES = 2;
endpackage

// File: rtl/ks_col_sync.sv
module ks_col_sync #(
  parameter int NUM_ROWS = 5,
  parameter int NUM_COLS = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_COLS-1:0]          col_n,
  input  logic [NUM_ROWS*NUM_COLS-1:0] image,
  output logic [NUM_COLS-1:0]          col_s,
  output logic                         diff
);
  logic [NUM_COLS-1:0] baseline;

  always_ff @(posedge clk) begin
    if (rst) col_s <= '1;
    else     col_s <= col_n;
  end

  // With all rows low, a column reads high only if no key on it is down
  always_comb begin
    for (int c = 0; c < NUM_COLS; c++) begin
      baseline[c] = 1'b1;
      for (int r = 0; r < NUM_ROWS; r++) begin
        if (image[r*NUM_COLS + c]) baseline[c] = 1'b0;
      end
    end
  end

  assign diff = (col_s != baseline);
endmodule

// File: rtl/ks_image.sv
module ks_image #(
  parameter int NUM_ROWS = 5,
  parameter int NUM_COLS = 6,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ROW_W-1:0]             row_sel,
  input  logic [NUM_COLS-1:0]          wr_data,
  input  logic                         rd_req,
  output logic [NUM_COLS-1:0]          row_old,
  output logic [NUM_ROWS*NUM_COLS-1:0] live,
  output logic [NUM_ROWS*NUM_COLS-1:0] captured
);
  logic [NUM_ROWS*NUM_COLS-1:0] img_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      img_q    <= '0;
      captured <= '0;
    end else begin
      if (wr_en) img_q[int'(row_sel)*NUM_COLS +: NUM_COLS] <= wr_data;
      if (rd_req) captured <= img_q;
    end
  end

  assign row_old = img_q[int'(row_sel)*NUM_COLS +: NUM_COLS];
  assign live    = img_q;
endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl #(
  parameter int NUM_ROWS  = 5,
  parameter int NUM_COLS  = 6,
  parameter int ROW_TICKS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [NUM_COLS-1:0]          col_n,
  input  logic                         stop_req,
  input  logic                         read_req,
  output logic [NUM_ROWS-1:0]          row_drv,
  output logic                         int_o,
  output logic [NUM_ROWS*NUM_COLS-1:0] key_image
);
  import keyscan_pkg::*;

  localparam int ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int TCNT_W = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1;
  localparam logic [ROW_W-1:0]    LAST_ROW  = ROW_W'(NUM_ROWS - 1);
  localparam logic [TCNT_W-1:0]   LAST_TICK = TCNT_W'(ROW_TICKS - 1);
  localparam logic [NUM_ROWS-1:0] ONE_ROW   = NUM_ROWS'(1);

  ks_state_t           state;
  logic [ROW_W-1:0]    row_idx;
  logic [TCNT_W-1:0]   tcnt;
  logic [1:0]          settle;
  logic                pend;
  logic                int_q;
  logic [NUM_ROWS-1:0] row_q;

  logic [NUM_COLS-1:0]          col_s;
  logic                         col_diff;
  logic [NUM_COLS-1:0]          row_old;
  logic [NUM_ROWS*NUM_COLS-1:0] img_live;
  logic                         last_tick;
  logic                         sample;
  logic [NUM_COLS-1:0]          pressed;

  assign last_tick = tick && (tcnt == LAST_TICK);
  assign sample    = (state == ST_SCAN) && !stop_req && last_tick;
  assign pressed   = ~col_s;

  ks_col_sync #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .col_n (col_n),
    .image (img_live),
    .col_s (col_s),
    .diff  (col_diff)
  );

  ks_image #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_img (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (sample),
    .row_sel  (row_idx),
    .wr_data  (pressed),
    .rd_req   (read_req),
    .row_old  (row_old),
    .live     (img_live),
    .captured (key_image)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      row_idx <= '0;
      tcnt    <= '0;
      settle  <= 2'(SETTLE_CYCLES);
      pend    <= 1'b0;
      int_q   <= 1'b0;
      row_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          row_q <= '0;
          if (settle != 2'd0) begin
            settle <= settle - 2'd1;
          end else if (col_diff) begin
            state   <= ST_SCAN;
            row_idx <= '0;
            tcnt    <= '0;
            row_q   <= ~ONE_ROW;
          end
        end
        ST_SCAN: begin
          if (stop_req) begin
            int_q <= 1'b0;
            row_q <= '0;
            tcnt  <= '0;
            pend  <= 1'b0;
            if (pend) begin
              state <= ST_PAUSE;
            end else begin
              state  <= ST_IDLE;
              settle <= 2'(SETTLE_CYCLES);
            end
          end else if (tick) begin
            if (last_tick) begin
              tcnt <= '0;
              if (int_q && (pressed != row_old)) pend <= 1'b1;
              if (row_idx == LAST_ROW) begin
                row_idx <= '0;
                int_q   <= 1'b1;
                row_q   <= ~ONE_ROW;
              end else begin
                row_idx <= row_idx + 1'b1;
                row_q   <= ~(ONE_ROW << (row_idx + 1'b1));
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_PAUSE: begin
          if (tick) begin
            if (last_tick) begin
              state   <= ST_SCAN;
              tcnt    <= '0;
              row_idx <= '0;
              row_q   <= ~ONE_ROW;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          row_q <= '0;
        end
      endcase
    end
  end

  assign row_drv = row_q;
  assign int_o   = int_q;
endmodule

// File: rtl/keyscan_ctrl_chk.sv
module keyscan_ctrl_chk #(
  parameter int NUM_ROWS = 5,
  parameter int NUM_COLS = 6
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         stop_req,
  input logic                         read_req,
  input logic [NUM_ROWS-1:0]          row_drv,
  input logic                         int_o,
  input logic [NUM_ROWS*NUM_COLS-1:0] key_image
);
  localparam logic [NUM_ROWS-1:0] ONE_ROW   = NUM_ROWS'(1);
  localparam logic [NUM_ROWS-1:0] FIRST_PAT = ~ONE_ROW;
  localparam logic [NUM_ROWS-1:0] LAST_PAT  = ~(ONE_ROW << (NUM_ROWS - 1));

  assert_one_row_R4: assert property (@(posedge clk) disable iff (rst)
    (row_drv != '0) |-> ($countones(~row_drv) == 1));

  assert_int_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(int_o) |-> $past(stop_req));

  assert_int_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(int_o) |-> (($past(row_drv) == LAST_PAT) && (row_drv == FIRST_PAT)));

  assert_stop_rows_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_req && (row_drv != '0)) |=> (row_drv == '0));

  assert_quiet_no_int_R7: assert property (@(posedge clk) disable iff (rst)
    (row_drv == '0) |-> !int_o);

  assert_image_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !read_req |=> $stable(key_image));
endmodule

bind keyscan_ctrl keyscan_ctrl_chk #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop_req  (stop_req),
  .read_req  (read_req),
  .row_drv   (row_drv),
  .int_o     (int_o),
  .key_image (key_image)
);

// File: tb/keyscan_ctrl_tb.sv
module keyscan_ctrl_tb;
  localparam int NR = 5;
  localparam int NC = 6;
  localparam int RT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic stop_req = 1'b0;
  logic read_req = 1'b0;
  logic [NC-1:0] col_n;
  logic [NR-1:0] row_drv;
  logic int_o;
  logic [NR*NC-1:0] key_image;
  logic [NR*NC-1:0] keys = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit m_valid = 1'b0;

  always #5 clk = ~clk;

  keyscan_ctrl #(.NUM_ROWS(NR), .NUM_COLS(NC), .ROW_TICKS(RT)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .col_n(col_n), .stop_req(stop_req),
    .read_req(read_req), .row_drv(row_drv), .int_o(int_o), .key_image(key_image)
  );

  // Key matrix: a pressed key pulls its column low when its row is driven low
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < NR; r++)
        if (keys[r*NC + c] && !row_drv[r]) col_n[c] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_state = 0, m_row = 0, m_tcnt = 0, m_settle = 2;
  bit m_pend = 0, m_int = 0;
  logic [NR-1:0] m_rows = '0;
  logic [NR*NC-1:0] m_img = '0, m_kimg = '0;
  logic [NC-1:0] m_cols = '1;

  function automatic logic [NR-1:0] pat(input int r);
    logic [NR-1:0] one = 1;
    return ~(one << r);
  endfunction

  always @(posedge clk) begin
    logic [NC-1:0] oc, pr, base;
    logic [NR*NC-1:0] oi;
    m_valid = 1'b1;
    oc = m_cols;
    oi = m_img;
    if (rst) begin
      m_state = 0; m_row = 0; m_tcnt = 0; m_settle = 2; m_pend = 0; m_int = 0;
      m_rows = '0; m_img = '0; m_kimg = '0; m_cols = '1;
    end else begin
      if (read_req) m_kimg = oi;
      for (int c = 0; c < NC; c++) begin
        base[c] = 1'b1;
        for (int r = 0; r < NR; r++) if (oi[r*NC + c]) base[c] = 1'b0;
      end
      pr = ~oc;
      if (m_state == 0) begin
        m_rows = '0;
        if (m_settle > 0) m_settle--;
        else if (oc != base) begin m_state = 1; m_row = 0; m_tcnt = 0; m_rows = pat(0); end
      end else if (m_state == 1) begin
        if (stop_req) begin
          m_int = 0; m_rows = '0; m_tcnt = 0;
          if (m_pend) m_state = 2; else begin m_state = 0; m_settle = 2; end
          m_pend = 0;
        end else if (tick) begin
          if (m_tcnt == RT - 1) begin
            m_tcnt = 0;
            if (m_int && (pr != oi[m_row*NC +: NC])) m_pend = 1;
            m_img[m_row*NC +: NC] = pr;
            if (m_row == NR - 1) begin m_row = 0; m_int = 1; end
            else m_row++;
            m_rows = pat(m_row);
          end else m_tcnt++;
        end
      end else begin
        if (tick) begin
          if (m_tcnt == RT - 1) begin m_state = 1; m_tcnt = 0; m_row = 0; m_rows = pat(0); end
          else m_tcnt++;
        end
      end
      m_cols = col_n;
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      check(row_drv == m_rows, "R4 row drive vs model", 64'(row_drv), 64'(m_rows));
      check(int_o == m_int, "R6 int vs model", 64'(int_o), 64'(m_int));
      check(key_image == m_kimg, "R10 key_image vs model", 64'(key_image), 64'(m_kimg));
    end
  end

  // Tick timebase: one tick every third clock
  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv + 1) % 3;
      tick = (tdiv == 0);
    end
  end

  task automatic pulse_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk) read_req = 1'b1;
    @(negedge clk) read_req = 1'b0;
  endtask

  task automatic wait_int(input string tag);
    int n = 0;
    while (!int_o && n < 400) begin @(negedge clk); n++; end
    check(int_o == 1'b1, tag, 64'(int_o), 64'd1);
  endtask

  task automatic wait_scan(input string tag);
    int n = 0;
    while (row_drv == '0 && n < 100) begin @(negedge clk); n++; end
    check(row_drv == pat(0), tag, 64'(row_drv), 64'(pat(0)));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [NR*NC-1:0] exp_img;
    repeat (3) @(negedge clk);
    check(row_drv == '0 && int_o == 1'b0 && key_image == '0, "R1 reset state",
          64'({row_drv, int_o}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(row_drv == '0 && int_o == 1'b0, "R1 first cycle after reset", 64'(row_drv), 64'd0);

    repeat (40) @(negedge clk);
    check(row_drv == '0, "R2 idle with no keys", 64'(row_drv), 64'd0);

    // Press: row 2, column 3
    keys[2*NC + 3] = 1'b1;
    wait_scan("R3 scan starts on press at row 0");
    wait_int("R6 int after first pass");
    pulse_read();
    exp_img = '0; exp_img[2*NC + 3] = 1'b1;
    check(key_image == exp_img, "R5 sampled image after press", 64'(key_image), 64'(exp_img));
    repeat (100) @(negedge clk);
    check(int_o == 1'b1, "R6 int holds until stop", 64'(int_o), 64'd1);

    pulse_stop();
    check(row_drv == '0 && int_o == 1'b0, "R7 stop returns to idle", 64'({row_drv, int_o}), 64'd0);
    repeat (60) @(negedge clk);
    check(row_drv == '0, "R2 held key matches baseline, stays idle", 64'(row_drv), 64'd0);

    pulse_stop();
    repeat (5) @(negedge clk);
    check(row_drv == '0 && int_o == 1'b0, "R9 stop while idle ignored", 64'({row_drv, int_o}), 64'd0);

    // Release restarts scanning
    keys[2*NC + 3] = 1'b0;
    wait_scan("R11 scan starts on release");
    wait_int("R6 int after release pass");
    pulse_read();
    check(key_image == '0, "R5 image cleared after release", 64'(key_image), 64'd0);

    // Change while int is high forces a second stop
    keys[4*NC + 5] = 1'b1;
    repeat (140) @(negedge clk);
    pulse_stop();
    check(row_drv == '0 && int_o == 1'b0, "R8 first stop pauses", 64'({row_drv, int_o}), 64'd0);
    pulse_stop();
    check(row_drv == '0, "R9 stop during pause has no visible effect", 64'(row_drv), 64'd0);
    wait_scan("R8 scanning resumes after pause");
    check(int_o == 1'b0, "R8 int low after resume", 64'(int_o), 64'd0);
    wait_int("R8 int after resumed pass");
    pulse_stop();
    check(row_drv == '0 && int_o == 1'b0, "R8 second stop reaches idle", 64'({row_drv, int_o}), 64'd0);
    repeat (60) @(negedge clk);
    check(row_drv == '0, "R8 stays idle after second stop", 64'(row_drv), 64'd0);

    // Several keys, including row 0 column 0 at bit 0
    keys[0] = 1'b1; keys[1*NC + 5] = 1'b1; keys[3*NC + 2] = 1'b1;
    wait_scan("R3 scan starts on multi-key press");
    wait_int("R6 int after multi-key pass");
    pulse_read();
    exp_img = '0;
    exp_img[0] = 1'b1; exp_img[1*NC + 5] = 1'b1; exp_img[3*NC + 2] = 1'b1; exp_img[4*NC + 5] = 1'b1;
    check(key_image == exp_img, "R10 image order with row0/col0 at bit 0", 64'(key_image), 64'(exp_img));
    check(key_image[0] == 1'b1, "R10 bit 0 is row 0 column 0", 64'(key_image[0]), 64'd1);
    repeat (30) @(negedge clk);
    check(key_image == exp_img, "R10 image holds without read", 64'(key_image), 64'(exp_img));

    finish_run();
  end
endmodule